// File: doc/BRIEF.md
# Two-Channel Transmit Byte Staging

This block sits between a register interface and a byte-wide transmit path. Software fills one of two byte FIFOs 32 bits at a time through a data register. A channel-select register decides which FIFO takes each data write. Each channel has its own frame-length register and its own start command.

When a start is accepted, the block streams bytes from that channel's FIFO on a valid/ready output and marks the final byte with a last flag. The number of bytes sent is the smaller of the programmed length and the number of bytes the FIFO holds. When the final byte is accepted, the block empties that channel, zeroes its length, and sets the channel's done bit. The done bits, gated by an enable mask, form a level interrupt.

Only one frame is in flight at a time, and the FIFO depth is a parameter. Register map (reg_addr): 0 control (bit 0 = transmit enable), 1 channel select, 2 data, 3 interrupt enable mask, 4+c length of channel c, 8+c start of channel c (bit 0), 12 done status (write 1 to clear).

Top module: `tx_stage_dual`

## Requirements
- R1: A write to address 2 appends its four bytes, bits 7:0 first and bits 31:24 last, to the FIFO named by the channel select.
- R2: A write to address 1 with a value below 2 selects that channel. Any larger value selects channel 0.
- R3: A start write (address 8+c, bit 0 = 1) has an effect only while control bit 0 is 1. A start that arrives while this bit is 0 leaves the channel's FIFO contents and length intact.
- R4: A data write that finds fewer than four free bytes in the selected FIFO is dropped. None of its bytes are stored.
- R5: A length write (address 4+c) whose value exceeds DEPTH stores DEPTH.
- R6: A frame carries min(length, bytes held) bytes. If that minimum is zero, nothing is sent and no done bit is set.
- R7: One byte is taken per cycle in which out_valid and out_ready are both high. out_last is high only on the final byte. While out_ready is low, out_data and out_last hold their values.
- R8: After the final byte of a frame is accepted, the channel's FIFO is emptied (bytes past the sent length are discarded), its length reads as zero, and bit c of tx_done_sta is set.
- R9: irq is high exactly when tx_done_sta ANDed with the enable mask (address 3) is non-zero. Writing a 1 to a bit at address 12 clears that done bit.
- R10: A start written while a frame is being sent is ignored, whichever channel it names.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Register write data |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of the frame |
| out_ready | input | 1 | Downstream accepts the byte |
| tx_done_sta | output | NUM_CH | Per-channel frame-done status |
| irq | output | 1 | Level interrupt |

## Verification
A wrong FIFO pointer or count shows up on the very first byte of the next frame, as a wrong value or a wrong frame length. The scoreboard compares every accepted byte against a model queue, so such an error is reported on that byte. A length or select register holding a bad value shows up as a frame that is too long, too short or taken from the wrong channel, and this appears no later than the final byte. A lost clear on a channel shows up on the next start of that channel as leftover bytes on the output. Faults in the status or the busy tracking show up on tx_done_sta and irq within a few cycles of the frame's end.

// File: rtl/txs_pkg.sv
package txs_pkg;
   localparam int ADDR_W     = 4;
   localparam int A_CTRL     = 0;
   localparam int A_CHSEL    = 1;
   localparam int A_DATA     = 2;
   localparam int A_IRQ_EN   = 3;
   localparam int A_LEN_BASE = 4;
   localparam int A_GO_BASE  = 8;
   localparam int A_IRQ_STA  = 12;
   localparam int WORD_BYTES = 4;
endpackage

// File: rtl/txs_byte_fifo.sv
module txs_byte_fifo #(
   parameter int DEPTH = 2048,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = PTR_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             push,
   input  logic [31:0]      wdata,
   input  logic             pop,
   output logic [7:0]       rdata,
   output logic [CNT_W-1:0] count,
   output logic             room
);
   logic [7:0]       mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;

   always_ff @(posedge clk) begin
      if (push) begin
         for (int k = 0; k < 4; k++) begin
            mem[wr_ptr + PTR_W'(k)] <= wdata[8*k +: 8];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + PTR_W'(4);
         if (pop)  rd_ptr <= rd_ptr + PTR_W'(1);
         count <= count + (push ? CNT_W'(4) : CNT_W'(0)) - (pop ? CNT_W'(1) : CNT_W'(0));
      end
   end

   assign rdata = mem[rd_ptr];
   assign room  = count <= CNT_W'(DEPTH - 4);
endmodule

// File: rtl/txs_drain_ctrl.sv
module txs_drain_ctrl #(
   parameter int NUM_CH = 2,
   parameter int CNT_W  = 12,
   parameter int CH_W   = 1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start_vld,
   input  logic [CH_W-1:0]              start_ch,
   input  logic [NUM_CH-1:0][CNT_W-1:0] lens,
   input  logic [NUM_CH-1:0][CNT_W-1:0] counts,
   input  logic                         out_ready,
   output logic                         busy,
   output logic [CH_W-1:0]              act_ch,
   output logic                         at_last,
   output logic [NUM_CH-1:0]            pop,
   output logic [NUM_CH-1:0]            done
);
   logic [CNT_W-1:0] remain, sel_len, sel_cnt, take;
   logic             hs;

   always_comb begin
      sel_len = lens[start_ch];
      sel_cnt = counts[start_ch];
      take    = (sel_len < sel_cnt) ? sel_len : sel_cnt;
   end

   assign hs      = busy && out_ready;
   assign at_last = busy && (remain == CNT_W'(1));
   assign pop     = hs ? (NUM_CH'(1) << act_ch) : '0;
   assign done    = (hs && at_last) ? (NUM_CH'(1) << act_ch) : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         remain <= '0;
         act_ch <= '0;
      end else if (busy) begin
         if (out_ready) begin
            remain <= remain - CNT_W'(1);
            if (at_last) busy <= 1'b0;
         end
      end else if (start_vld && take != '0) begin
         busy   <= 1'b1;
         remain <= take;
         act_ch <= start_ch;
      end
   end
endmodule

// File: rtl/tx_stage_dual.sv
module tx_stage_dual
   import txs_pkg::*;
#(
   parameter int DEPTH  = 2048,
   parameter int NUM_CH = 2,
   localparam int CNT_W = $clog2(DEPTH) + 1,
   localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [3:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic              out_valid,
   output logic [7:0]        out_data,
   output logic              out_last,
   input  logic              out_ready,
   output logic [NUM_CH-1:0] tx_done_sta,
   output logic              irq
);
   initial begin
      assert (DEPTH >= 8 && (DEPTH & (DEPTH - 1)) == 0)
         else $error("DEPTH must be a power of two of at least 8");
      assert (NUM_CH >= 2 && NUM_CH <= 4)
         else $error("NUM_CH must be 2 to 4");
   end

   logic                         tx_en;
   logic [CH_W-1:0]              ch_sel;
   logic [NUM_CH-1:0]            irq_en;
   logic [NUM_CH-1:0][CNT_W-1:0] len_q, cnt;
   logic [NUM_CH-1:0][7:0]       rd_byte;
   logic [NUM_CH-1:0]            room, pop, done;
   logic                         busy, at_last, go_hit, go_vld;
   logic [CH_W-1:0]              act_ch, go_ch;

   function automatic logic hit(input logic [3:0] a, input int target);
      return reg_wr && (a == ADDR_W'(target));
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_en       <= 1'b0;
         ch_sel      <= '0;
         irq_en      <= '0;
         tx_done_sta <= '0;
      end else begin
         if (hit(reg_addr, A_CTRL))   tx_en  <= reg_wdata[0];
         if (hit(reg_addr, A_CHSEL))  ch_sel <= (reg_wdata < 32'(NUM_CH)) ? reg_wdata[CH_W-1:0] : '0;
         if (hit(reg_addr, A_IRQ_EN)) irq_en <= reg_wdata[NUM_CH-1:0];
         tx_done_sta <= (tx_done_sta &
                         ~(hit(reg_addr, A_IRQ_STA) ? reg_wdata[NUM_CH-1:0] : '0)) | done;
      end
   end

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         logic push;
         assign push = hit(reg_addr, A_DATA) && (ch_sel == CH_W'(c)) && room[c];

         always_ff @(posedge clk) begin
            if (!rst_n || done[c]) begin
               len_q[c] <= '0;
            end else if (hit(reg_addr, A_LEN_BASE + c)) begin
               len_q[c] <= (reg_wdata > 32'(DEPTH)) ? CNT_W'(DEPTH) : reg_wdata[CNT_W-1:0];
            end
         end

         txs_byte_fifo #(.DEPTH(DEPTH)) u_fifo (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (done[c]),
            .push  (push),
            .wdata (reg_wdata),
            .pop   (pop[c]),
            .rdata (rd_byte[c]),
            .count (cnt[c]),
            .room  (room[c])
         );
      end
   endgenerate

   assign go_hit = reg_wr && (reg_addr >= ADDR_W'(A_GO_BASE)) &&
                   (reg_addr < ADDR_W'(A_GO_BASE + NUM_CH));
   assign go_ch  = CH_W'(reg_addr - ADDR_W'(A_GO_BASE));
   assign go_vld = go_hit && reg_wdata[0] && tx_en;

   txs_drain_ctrl #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .CH_W(CH_W)) u_drain (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_vld (go_vld),
      .start_ch  (go_ch),
      .lens      (len_q),
      .counts    (cnt),
      .out_ready (out_ready),
      .busy      (busy),
      .act_ch    (act_ch),
      .at_last   (at_last),
      .pop       (pop),
      .done      (done)
   );

   assign out_valid = busy;
   assign out_data  = rd_byte[act_ch];
   assign out_last  = at_last;
   assign irq       = |(tx_done_sta & irq_en);
endmodule

module tx_stage_dual_chk #(
   parameter int NUM_CH = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [3:0]        reg_addr,
   input logic [31:0]       reg_wdata,
   input logic              out_valid,
   input logic [7:0]        out_data,
   input logic              out_last,
   input logic              out_ready,
   input logic [NUM_CH-1:0] tx_done_sta,
   input logic              irq
);
   // R7
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

   // R10
   frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_ready && out_last |=> !out_valid);

   // R8
   done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_ready && out_last |=> tx_done_sta != '0);

   // R3
   start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> $past(reg_wr && reg_addr >= 4'd8 &&
                                 reg_addr < 4'(8 + NUM_CH) && reg_wdata[0]));

   // R9
   irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_done_sta == '0 |-> !irq);
endmodule

bind tx_stage_dual tx_stage_dual_chk #(.NUM_CH(NUM_CH)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .reg_wr      (reg_wr),
   .reg_addr    (reg_addr),
   .reg_wdata   (reg_wdata),
   .out_valid   (out_valid),
   .out_data    (out_data),
   .out_last    (out_last),
   .out_ready   (out_ready),
   .tx_done_sta (tx_done_sta),
   .irq         (irq)
);

// File: tb/tx_stage_dual_bench.sv
`timescale 1ns/1ps
module tx_stage_dual_bench;
   localparam int DEPTH = 2048;

   logic        clk = 0;
   logic        rst_n = 0;
   logic        reg_wr = 0;
   logic [3:0]  reg_addr = 0;
   logic [31:0] reg_wdata = 0;
   logic        out_valid, out_last, irq;
   logic [7:0]  out_data;
   logic        out_ready = 1;
   logic [1:0]  tx_done_sta;

   int total = 0;
   int bad = 0;
   bit finished = 0;
   string cur_req = "R1";

   logic [7:0]  mq [2][$];
   logic [9:0]  expq [$];      // {ch, last, data}
   int          mlen [2];
   int          msel = 0;
   bit          men = 0;
   bit          mbusy = 0;
   logic [1:0]  msta = 0;
   logic [1:0]  mirq_en = 0;

   always #4 clk = ~clk;

   tx_stage_dual u_tx_stage_dual (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .out_valid(out_valid), .out_data(out_data),
      .out_last(out_last), .out_ready(out_ready), .tx_done_sta(tx_done_sta),
      .irq(irq)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && out_valid && out_ready) begin
         if (expq.size() == 0) begin
            check(0, cur_req, out_data, 'hxx);
         end else begin
            logic [9:0] e;
            e = expq.pop_front();
            check(out_data == e[7:0] && out_last == e[8], cur_req,
                  {out_last, out_data}, e[8:0]);
            if (e[8]) begin
               mbusy = 0;
               msta[e[9]] = 1'b1;
            end
         end
      end
   end

   task automatic wr(input int addr, input logic [31:0] data);
      @(negedge clk);
      reg_wr = 1; reg_addr = 4'(addr); reg_wdata = data;
      case (addr)
         0: men = data[0];
         1: msel = (data < 2) ? int'(data) : 0;
         2: if (mq[msel].size() <= DEPTH - 4)
               for (int k = 0; k < 4; k++) mq[msel].push_back(data[8*k +: 8]);
         3: mirq_en = data[1:0];
         4, 5: mlen[addr-4] = (data > DEPTH) ? DEPTH : int'(data);
         8, 9: begin
            int c, n;
            c = addr - 8;
            n = (mlen[c] < mq[c].size()) ? mlen[c] : mq[c].size();
            if (men && data[0] && !mbusy && n > 0) begin
               for (int k = 0; k < n; k++)
                  expq.push_back({c[0], (k == n - 1), mq[c][k]});
               mq[c].delete();
               mlen[c] = 0;
               mbusy = 1;
            end
         end
         12: msta = msta & ~data[1:0];
         default: ;
      endcase
      @(negedge clk);
      reg_wr = 0;
   endtask

   task automatic wait_idle();
      while (expq.size() != 0 || out_valid) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   task automatic check_status(input string req);
      check(tx_done_sta == msta, req, tx_done_sta, msta);
      check(irq == |(msta & mirq_en), req, irq, |(msta & mirq_en));
   endtask

   task automatic expect_quiet(input int n, input string req);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         check(!out_valid, req, out_valid, 0);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         bad++; total++;
         $display("FAIL watchdog: actual=running expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // reset state
      check(!out_valid && tx_done_sta == 0 && !irq, "R8", {out_valid, tx_done_sta, irq}, 0);

      // R1 byte order, R7 last marker
      cur_req = "R1";
      wr(0, 1); wr(1, 0); wr(2, 32'h44332211); wr(4, 4); wr(8, 1);
      wait_idle();
      check_status("R8");

      // R9 enable mask and write-one-to-clear
      cur_req = "R9";
      wr(3, 1);
      check_status("R9");
      check(irq == 1, "R9", irq, 1);
      wr(12, 1);
      check_status("R9");
      check(irq == 0, "R9", irq, 0);

      // R2 out-of-range select falls back to channel 0
      cur_req = "R2";
      wr(1, 1); wr(1, 3); wr(2, 32'hA5B6C7D8); wr(4, 4); wr(8, 1);
      wait_idle();
      check_status("R2");
      wr(12, 3);

      // R6 length clamped to bytes held, zero sends nothing
      cur_req = "R6";
      wr(2, 32'h0F0E0D0C); wr(2, 32'h13121110); wr(4, 10); wr(8, 1);
      wait_idle();
      wr(12, 3);
      wr(2, 32'h77665544); wr(4, 0); wr(8, 1);
      expect_quiet(6, "R6");
      check_status("R6");

      // R8 leftover bytes discarded after send
      cur_req = "R8";
      wr(2, 32'hBBAA9988); wr(4, 4); wr(8, 1);
      wait_idle();
      wr(12, 3);
      wr(4, 4); wr(8, 1);
      expect_quiet(6, "R8");
      check_status("R8");

      // R3 start ignored while transmit disabled, state kept
      cur_req = "R3";
      wr(0, 0); wr(1, 1); wr(2, 32'hDEADBEEF); wr(5, 4); wr(9, 1);
      expect_quiet(6, "R3");
      wr(0, 1); wr(9, 1);
      wait_idle();
      check_status("R3");
      wr(12, 3);

      // R10 starts during a send are ignored
      cur_req = "R10";
      wr(1, 1); wr(2, 32'h31302F2E); wr(2, 32'h35343332); wr(5, 8);
      wr(1, 0); wr(2, 32'h21201F1E); wr(2, 32'h25242322); wr(4, 8);
      @(posedge clk); #1 out_ready = 0;
      wr(8, 1);
      wr(8, 1); wr(9, 1);
      @(posedge clk); #1 out_ready = 1;
      wait_idle();
      check_status("R10");
      wr(9, 1);
      wait_idle();
      check_status("R10");
      wr(12, 3);

      // R7 back-pressure pattern
      cur_req = "R7";
      for (int k = 0; k < 3; k++) wr(2, 32'h01010101 * (k + 5) + 32'h03020100);
      wr(4, 12); wr(8, 1);
      for (int k = 0; k < 60; k++) begin
         @(posedge clk); #1 out_ready = (k % 3) != 1;
      end
      out_ready = 1;
      wait_idle();
      check_status("R7");
      wr(12, 3);

      // R4 overflow drop, R5 length clamp
      cur_req = "R4";
      wr(1, 1);
      for (int k = 0; k < DEPTH / 4 + 1; k++) wr(2, 32'h01010101 * k + 32'h03020100);
      check(mq[1].size() == DEPTH, "R4", mq[1].size(), DEPTH);
      cur_req = "R5";
      wr(5, 5000); wr(9, 1);
      wait_idle();
      check_status("R5");

      check(expq.size() == 0, "R6", expq.size(), 0);
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule